// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on the CPU side of a system controller and sorts every CPU address into one of a set of software-programmed windows (device selects, PCI I/O, PCI memory) or into a fixed 4 KB slice holding the controller's own registers. Each window is described by three registers: a low-decode register, a high-decode register and a remap register. All of them, and the base of the register slice, are loaded through one simple write port. Windows are placed in 2 MB pages. A window with an empty page range decodes nothing.

A request presents a 32-bit address, an access size and write data. One cycle later the block reports one of three results: a hit in the register slice, a one-hot hit in one window, or a miss. It also returns the translated address. Memory windows are translated through their remap register. The I/O window forwards only a 16-bit port address. In big-endian mode, half-word and word data crossing the I/O window are byte-swapped in both directions. A two-state machine (`ST_IDLE`, `ST_RESP`) tracks whether a result is on the outputs. It moves `ST_IDLE`→`ST_RESP` and stays in `ST_RESP` while `req_valid` is high. It returns `ST_RESP`→`ST_IDLE` and stays in `ST_IDLE` while `req_valid` is low.

Top module: `addr_win_decoder`

## Requirements
- R1: Register slots are selected by `cfg_addr`. The slot for window w is w*4 + field, where field 0 is low-decode, field 1 is high-decode and field 2 is remap. The register-slice base sits at slot NUM_WIN*4. The low and slice registers keep write bits [14:0], the high register keeps [6:0] and the remap register keeps [10:0]. All higher write bits are dropped.
- R2: A write to a window's low-decode slot also loads that window's remap register with write bits [10:0].
- R3: An active window covers addresses from low[10:0]·2^21 up to, but not including, that base plus ((high+1) − low[6:0])·2 MB.
- R4: A window is active only while low[6:0] ≤ high. Equality gives one 2 MB page. A window with low[6:0] > high never hits.
- R5: For a memory window the translated address is remap·2^21 + (addr − base), taken modulo 2^32.
- R6: The register slice covers 4 KB starting at slice[10:0]·2^21. Its translated address is addr − slice base.
- R7: When a result is shown, exactly one of `rsp_hit_int`, the bits of `rsp_hit_win` and `rsp_miss` is set. The register slice wins over every window, and a lower window index wins over a higher one.
- R8: For the I/O window (index IO_WIN) the translated address is {16'b0, (addr − base)[15:0]}.
- R9: Size codes are 0 byte, 1 half-word and 2 word. With `big_endian` set and an I/O-window hit, a half-word becomes {16'h0, d[7:0], d[15:8]} and a word is fully byte-reversed. This applies both to `rsp_io_wdata` and to `rsp_rdata` from `io_rdata`. A byte access, any other window, or little-endian mode passes data unchanged.
- R10: Results appear one cycle after `req_valid`, and `rsp_valid` is low in a cycle after no request. A configuration write steers requests sampled at later edges. A request sampled on the same edge as the write uses the old values.
- R11: Reset makes every window inactive (low 0x07F, high 0, remap 0x07F), sets the slice register to 0x0DF (base 0x1BE00000) and clears all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration slot select |
| cfg_wdata | input | 32 | Configuration write data |
| big_endian | input | 1 | Byte-swap enable for I/O window data |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 32 | CPU address |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | CPU write data |
| io_rdata | input | 32 | Read data returned from the I/O side |
| rsp_valid | output | 1 | Result valid |
| rsp_hit_int | output | 1 | Hit in the register slice |
| rsp_hit_win | output | NUM_WIN | One-hot window hit |
| rsp_miss | output | 1 | No window matched |
| rsp_addr | output | 32 | Translated address |
| rsp_io_wdata | output | 32 | Write data toward the I/O side, swapped when required |
| rsp_rdata | output | 32 | Read data toward the CPU, swapped when required |

## Verification
The hardest cases to reach from the ports are the overlap cases. The first is a single address that falls in the register slice, in a lower window and in a higher window at once. The second is a configuration write that lands on the same edge as a request. The stimulus moves the register slice onto the start of the I/O window and places a second window inside a first one, so the priority order is observed directly. It then drives a high-register write and a request into the same clock cycle, and repeats the request, so the old and new decodes are both seen. Window edges are covered by probing the last word inside a window, the first word past it, and a window whose low field equals its high field.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int ADDR_W      = 32;
    localparam int PAGE_LSB    = 21;
    localparam int PAGE_W      = ADDR_W - PAGE_LSB;
    localparam int LOW_W       = 15;
    localparam int HIGH_W      = 7;
    localparam int REMAP_W     = 11;
    localparam int SLOT_STRIDE = 4;
    localparam int INT_LSB     = 12;

    typedef struct packed {
        logic [LOW_W-1:0]   low;
        logic [HIGH_W-1:0]  high;
        logic [REMAP_W-1:0] remap;
    } win_cfg_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    function automatic logic [31:0] lane_swap(input logic [31:0] d, input logic [1:0] sz);
        logic [31:0] r;
        case (sz)
            SZ_HALF: r = {16'h0000, d[7:0], d[15:8]};
            SZ_WORD: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: r = d;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs
    import awd_pkg::*;
#(
    parameter int                  NUM_WIN  = 4,
    parameter int                  CFG_AW   = 5,
    parameter logic [LOW_W-1:0]    DEF_LOW  = 15'h007F,
    parameter logic [HIGH_W-1:0]   DEF_HIGH = 7'h00,
    parameter logic [LOW_W-1:0]    DEF_ISD  = 15'h00DF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [31:0]                  cfg_wdata,
    output win_cfg_t [NUM_WIN-1:0]       win_cfg,
    output logic [LOW_W-1:0]             isd_q
);
    localparam logic [CFG_AW-1:0] ISD_SLOT = CFG_AW'(NUM_WIN * SLOT_STRIDE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isd_q <= DEF_ISD;
        end else if (cfg_we && cfg_addr == ISD_SLOT) begin
            isd_q <= cfg_wdata[LOW_W-1:0];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [CFG_AW-1:0] A_LOW   = CFG_AW'(w * SLOT_STRIDE);
        localparam logic [CFG_AW-1:0] A_HIGH  = CFG_AW'(w * SLOT_STRIDE + 1);
        localparam logic [CFG_AW-1:0] A_REMAP = CFG_AW'(w * SLOT_STRIDE + 2);
        win_cfg_t wq;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wq <= '{low: DEF_LOW, high: DEF_HIGH, remap: DEF_LOW[REMAP_W-1:0]};
            end else if (cfg_we) begin
                if (cfg_addr == A_LOW) begin
                    wq.low   <= cfg_wdata[LOW_W-1:0];
                    wq.remap <= cfg_wdata[REMAP_W-1:0];
                end
                if (cfg_addr == A_HIGH)  wq.high  <= cfg_wdata[HIGH_W-1:0];
                if (cfg_addr == A_REMAP) wq.remap <= cfg_wdata[REMAP_W-1:0];
            end
        end
        assign win_cfg[w] = wq;

        // Low-decode write reloads the remap register
        assert_remap_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == A_LOW) |=> (win_cfg[w].remap == $past(cfg_wdata[REMAP_W-1:0])));
        // High register keeps only its field bits
        assert_high_trunc_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == A_HIGH) |=> (win_cfg[w].high == $past(cfg_wdata[HIGH_W-1:0])));
    end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import awd_pkg::*;
#(
    parameter bit IS_IO = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  win_cfg_t          cfg,
    output logic              hit,
    output logic [ADDR_W-1:0] xlat
);
    logic [PAGE_W-1:0] page;
    logic              active;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;
    logic              unused_low_hi;

    assign page   = addr[ADDR_W-1:PAGE_LSB];
    assign active = (cfg.low[HIGH_W-1:0] <= cfg.high);
    // Window never crosses a 256 MB boundary: upper page bits must match,
    // lower page bits lie between low[6:0] and high.
    assign hit    = active
                 && (page[PAGE_W-1:HIGH_W] == cfg.low[PAGE_W-1:HIGH_W])
                 && (page[HIGH_W-1:0] >= cfg.low[HIGH_W-1:0])
                 && (page[HIGH_W-1:0] <= cfg.high);
    assign base   = {cfg.low[PAGE_W-1:0], {PAGE_LSB{1'b0}}};
    assign offset = addr - base;
    assign unused_low_hi = ^cfg.low[LOW_W-1:PAGE_W];

    if (IS_IO) begin : g_io
        logic unused_io;
        assign unused_io = ^{cfg.remap, offset[ADDR_W-1:16]};
        assign xlat = {16'h0000, offset[15:0]};
    end else begin : g_mem
        assign xlat = {cfg.remap, {PAGE_LSB{1'b0}}} + offset;
    end
endmodule

// File: rtl/awd_prio.sv
module awd_prio
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                            int_hit,
    input  logic [ADDR_W-1:0]               int_xlat,
    input  logic [NUM_WIN-1:0]              win_hit,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_xlat,
    output logic                            sel_int,
    output logic [NUM_WIN-1:0]              sel_win,
    output logic                            sel_miss,
    output logic [ADDR_W-1:0]               sel_xlat
);
    always_comb begin
        logic found;
        sel_int  = 1'b0;
        sel_win  = '0;
        sel_xlat = '0;
        found    = 1'b0;
        if (int_hit) begin
            sel_int  = 1'b1;
            sel_xlat = int_xlat;
            found    = 1'b1;
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (!found && win_hit[i]) begin
                sel_win[i] = 1'b1;
                sel_xlat   = win_xlat[i];
                found      = 1'b1;
            end
        end
        sel_miss = !found;
    end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import awd_pkg::*;
#(
    parameter int                NUM_WIN  = 4,
    parameter int                IO_WIN   = 0,
    parameter int                CFG_AW   = $clog2(NUM_WIN * SLOT_STRIDE + 1),
    parameter logic [LOW_W-1:0]  DEF_LOW  = 15'h007F,
    parameter logic [HIGH_W-1:0] DEF_HIGH = 7'h00,
    parameter logic [LOW_W-1:0]  DEF_ISD  = 15'h00DF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                big_endian,
    input  logic                req_valid,
    input  logic [31:0]         req_addr,
    input  logic [1:0]          req_size,
    input  logic [31:0]         req_wdata,
    input  logic [31:0]         io_rdata,
    output logic                rsp_valid,
    output logic                rsp_hit_int,
    output logic [NUM_WIN-1:0]  rsp_hit_win,
    output logic                rsp_miss,
    output logic [31:0]         rsp_addr,
    output logic [31:0]         rsp_io_wdata,
    output logic [31:0]         rsp_rdata
);
    typedef enum logic {ST_IDLE = 1'b0, ST_RESP = 1'b1} st_t;

    win_cfg_t [NUM_WIN-1:0]           win_cfg;
    logic [LOW_W-1:0]                 isd_q;
    logic [NUM_WIN-1:0]               win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0]   win_xlat;
    logic                             int_hit;
    logic [ADDR_W-1:0]                int_base;
    logic [ADDR_W-1:0]                int_xlat;
    logic                             sel_int, sel_miss;
    logic [NUM_WIN-1:0]               sel_win;
    logic [ADDR_W-1:0]                sel_xlat;
    logic                             io_swap;
    logic                             unused_isd_hi;
    st_t                              state_q, state_d;
    logic                             rd_swap_q;
    logic [1:0]                       rd_size_q;

    awd_cfg_regs #(
        .NUM_WIN (NUM_WIN), .CFG_AW (CFG_AW),
        .DEF_LOW (DEF_LOW), .DEF_HIGH (DEF_HIGH), .DEF_ISD (DEF_ISD)
    ) u_regs (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .win_cfg (win_cfg), .isd_q (isd_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        awd_win_match #(.IS_IO (w == IO_WIN)) u_match (
            .addr (req_addr), .cfg (win_cfg[w]),
            .hit (win_hit[w]), .xlat (win_xlat[w])
        );
    end

    // Fixed 4 KB register slice
    assign int_base      = {isd_q[PAGE_W-1:0], {PAGE_LSB{1'b0}}};
    assign int_hit       = (req_addr[ADDR_W-1:INT_LSB] == int_base[ADDR_W-1:INT_LSB]);
    assign int_xlat      = {{(ADDR_W-INT_LSB){1'b0}}, req_addr[INT_LSB-1:0]};
    assign unused_isd_hi = ^isd_q[LOW_W-1:PAGE_W];

    awd_prio #(.NUM_WIN (NUM_WIN)) u_prio (
        .int_hit (int_hit), .int_xlat (int_xlat),
        .win_hit (win_hit), .win_xlat (win_xlat),
        .sel_int (sel_int), .sel_win (sel_win),
        .sel_miss (sel_miss), .sel_xlat (sel_xlat)
    );

    assign io_swap = big_endian && sel_win[IO_WIN];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit_int  <= 1'b0;
            rsp_hit_win  <= '0;
            rsp_miss     <= 1'b0;
            rsp_addr     <= '0;
            rsp_io_wdata <= '0;
            rd_swap_q    <= 1'b0;
            rd_size_q    <= SZ_BYTE;
        end else if (req_valid) begin
            rsp_hit_int  <= sel_int;
            rsp_hit_win  <= sel_win;
            rsp_miss     <= sel_miss;
            rsp_addr     <= sel_xlat;
            rsp_io_wdata <= io_swap ? lane_swap(req_wdata, req_size) : req_wdata;
            rd_swap_q    <= io_swap;
            rd_size_q    <= req_size;
        end else begin
            rsp_hit_int  <= 1'b0;
            rsp_hit_win  <= '0;
            rsp_miss     <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = rd_swap_q ? lane_swap(io_rdata, rd_size_q) : io_rdata;

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit_int && !rsp_miss && rsp_hit_win == '0));
    assert_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit_int, rsp_hit_win, rsp_miss}) == 1));
    assert_int_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit_int) |-> (rsp_addr[ADDR_W-1:INT_LSB] == '0));
    assert_io_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit_win[IO_WIN]) |-> (rsp_addr[ADDR_W-1:16] == '0));
    assert_no_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit_win[IO_WIN]) |-> (rsp_io_wdata == $past(req_wdata)));
endmodule

// File: tb/tb_addr_win_decoder.sv
`timescale 1ns/1ps
module tb_addr_win_decoder;
    localparam int NW = 4;
    localparam int AW = 5;
    localparam int NV = 11;
    // Table: address and the requirement each probe targets
    localparam logic [31:0] VEC_ADDR [NV] = '{
        32'h1E000010, 32'h1E001000, 32'h1E3FFFFC, 32'h1E400000,
        32'h10000000, 32'h107FFFFF, 32'h10800000, 32'h10200004,
        32'h00A00000, 32'h00000000, 32'h1BE00000 };
    localparam int VEC_REQ [NV] = '{7, 8, 3, 3, 5, 3, 3, 7, 4, 3, 6};

    logic clk = 0, rst_n = 0, cfg_we = 0, big_endian = 0, req_valid = 0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, req_addr = '0, req_wdata = '0, io_rdata = '0;
    logic [1:0] req_size = 2'd2;
    logic rsp_valid, rsp_hit_int, rsp_miss;
    logic [NW-1:0] rsp_hit_win;
    logic [31:0] rsp_addr, rsp_io_wdata, rsp_rdata;

    int checks = 0, errors = 0;
    logic [14:0] sh_low [NW];
    logic [6:0]  sh_high [NW];
    logic [10:0] sh_remap [NW];
    logic [14:0] sh_isd;

    always #10 clk = ~clk;

    addr_win_decoder #(.NUM_WIN(NW), .IO_WIN(0)) dut (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .big_endian,
        .req_valid, .req_addr, .req_size, .req_wdata, .io_rdata,
        .rsp_valid, .rsp_hit_int, .rsp_hit_win, .rsp_miss,
        .rsp_addr, .rsp_io_wdata, .rsp_rdata);

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic shadow_wr(input int a, input logic [31:0] d);
        if (a == NW * 4) sh_isd = d[14:0];
        else if (a % 4 == 0) begin sh_low[a/4] = d[14:0]; sh_remap[a/4] = d[10:0]; end
        else if (a % 4 == 1) sh_high[a/4] = d[6:0];
        else if (a % 4 == 2) sh_remap[a/4] = d[10:0];
    endtask

    task automatic cfg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        shadow_wr(a, d);
    endtask

    task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
    endtask

    // Reference: code 0 = register slice, i+1 = window i, 15 = miss
    task automatic model(input logic [31:0] a, output int code, output logic [31:0] x);
        longint la, base, len, ib;
        la = longint'(a);
        code = 15; x = 32'h0;
        for (int i = NW - 1; i >= 0; i--) begin
            base = longint'(sh_low[i][10:0]) << 21;
            len  = (longint'(sh_high[i]) + 1 - longint'(sh_low[i][6:0])) << 21;
            if (sh_low[i][6:0] <= sh_high[i] && la >= base && la < base + len) begin
                code = i + 1;
                if (i == 0) x = {16'h0, 16'(la - base)};
                else        x = 32'((longint'(sh_remap[i]) << 21) + (la - base));
            end
        end
        ib = longint'(sh_isd[10:0]) << 21;
        if (la >= ib && la < ib + 4096) begin code = 0; x = 32'(la - ib); end
    endtask

    function automatic int dut_code();
        if (rsp_hit_int) return 0;
        if (rsp_miss) return 15;
        for (int i = 0; i < NW; i++) if (rsp_hit_win[i]) return i + 1;
        return 99;
    endfunction

    task automatic probe(input logic [31:0] a, input string rq);
        int ec; logic [31:0] ex;
        model(a, ec, ex);
        do_req(a, 2'd2, 32'h0);
        check(rsp_valid && dut_code() == ec, {rq, " window"}, 32'(dut_code()), 32'(ec));
        if (ec != 15) check(rsp_addr == ex, {rq, " address"}, rsp_addr, ex);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin sh_low[i] = 15'h7F; sh_high[i] = 0; sh_remap[i] = 11'h7F; end
        sh_isd = 15'h0DF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state of outputs
        check(!rsp_valid && !rsp_hit_int && !rsp_miss && rsp_hit_win == 0, "R11 reset outputs",
              {rsp_valid, rsp_hit_int, rsp_miss, rsp_hit_win}, 32'h0);
        probe(32'h1BE00004, "R11 slice default");
        probe(32'h00000000, "R11 disabled");
        probe(32'h0FE00000, "R11 default base");

        // Configuration (R1 truncation on W1 and slice)
        cfg_wr(0*4+0, 32'h000000F0);   // W0 I/O base 0x1E000000
        cfg_wr(0*4+1, 32'h00000071);   // 2 pages
        cfg_wr(1*4+0, 32'hFFFF8080);   // W1 base 0x10000000, R1 drop upper bits
        cfg_wr(1*4+1, 32'hFFFFFF03);   // R1: high keeps 7 bits
        cfg_wr(1*4+2, 32'hFFFFF200);   // remap 0x200
        cfg_wr(2*4+0, 32'h00000081);   // W2 inside W1
        cfg_wr(2*4+1, 32'h00000001);
        cfg_wr(3*4+0, 32'h00000005);   // W3 disabled (R4)
        cfg_wr(3*4+1, 32'h00000002);
        cfg_wr(NW*4,  32'hFFFF80F0);   // slice onto W0 start
        check(sh_high[1] == 7'h03, "R1 shadow", 32'(sh_high[1]), 32'h3);
        do_req(32'h10000000, 2'd2, 32'h0);
        check(rsp_addr == 32'h40000000, "R1 remap truncated", rsp_addr, 32'h40000000);

        // Table walk
        for (int v = 0; v < NV; v++) probe(VEC_ADDR[v], $sformatf("R%0d vec%0d", VEC_REQ[v], v));

        // R10: same-cycle write uses old decode, next request sees new
        @(negedge clk);
        cfg_we = 1; cfg_addr = AW'(3*4+1); cfg_wdata = 32'h7;
        req_valid = 1; req_addr = 32'h00A00000;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        check(rsp_valid && rsp_miss, "R10 old decode", {rsp_valid, rsp_miss}, 2'b11);
        @(negedge clk);
        check(!rsp_valid, "R10 idle after request", 32'(rsp_valid), 32'h0);
        shadow_wr(3*4+1, 32'h7);
        probe(32'h00A00000, "R10 new decode");

        // R4 boundary: low[6:0]==high gives one page; R2 remap load
        cfg_wr(2*4+0, 32'h000000C0);
        cfg_wr(2*4+1, 32'h00000040);
        probe(32'h181FFFF0, "R2 equal bounds");
        probe(32'h18200000, "R3 past end");
        cfg_wr(2*4+2, 32'h000003FF);
        do_req(32'h181FFFF0, 2'd2, 32'h0);
        check(rsp_hit_win == 4'b0100 && rsp_addr == 32'h7FFFFFF0, "R5 remap wrap", rsp_addr, 32'h7FFFFFF0);
        cfg_wr(2*4+1, 32'h0000003F);
        probe(32'h18000000, "R4 disabled");

        // R9 byte swap
        big_endian = 1;
        io_rdata = 32'hA1B2C3D4;
        do_req(32'h1E100020, 2'd2, 32'h11223344);
        check(rsp_hit_win[0] && rsp_addr == 32'h00000020, "R8 port addr", rsp_addr, 32'h20);
        check(rsp_io_wdata == 32'h44332211, "R9 word write", rsp_io_wdata, 32'h44332211);
        #1 check(rsp_rdata == 32'hD4C3B2A1, "R9 word read", rsp_rdata, 32'hD4C3B2A1);
        io_rdata = 32'h00001234;
        do_req(32'h1E100022, 2'd1, 32'h0000ABCD);
        check(rsp_io_wdata == 32'h0000CDAB, "R9 half write", rsp_io_wdata, 32'h0000CDAB);
        #1 check(rsp_rdata == 32'h00003412, "R9 half read", rsp_rdata, 32'h00003412);
        do_req(32'h1E100023, 2'd0, 32'h0000005A);
        check(rsp_io_wdata == 32'h0000005A, "R9 byte write", rsp_io_wdata, 32'h5A);
        #1 check(rsp_rdata == 32'h00001234, "R9 byte read", rsp_rdata, 32'h1234);
        io_rdata = 32'hA1B2C3D4;
        do_req(32'h10000010, 2'd2, 32'h11223344);
        check(rsp_io_wdata == 32'h11223344, "R9 mem window", rsp_io_wdata, 32'h11223344);
        #1 check(rsp_rdata == 32'hA1B2C3D4, "R9 mem read", rsp_rdata, 32'hA1B2C3D4);
        big_endian = 0;
        do_req(32'h1E100020, 2'd2, 32'h11223344);
        check(rsp_io_wdata == 32'h11223344, "R9 little endian", rsp_io_wdata, 32'h11223344);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule